// File: doc/BRIEF.md
# Serial Port with Fractional Baud Accumulator

This block is a register-mapped asynchronous serial port for an on-chip bus. Software writes bytes into a transmit queue. Each byte is sent as one frame of ten bit periods: a low start bit, eight data bits with the least significant bit first, and a high stop bit. The receive side decodes frames of the same shape into a one-byte holding register, which software empties by reading it.

The bit rate comes from a 16-bit increment held in the control word. On every clock the increment is added to a 20-bit phase accumulator, and each carry out of the accumulator is one sample tick. One bit period lasts `OVERSAMPLE` ticks. Four event sources (transmit watermark, receive watermark, transmit empty, receive overflow) each have a latched state bit and a mask bit. Software clears state bits by writing 1 to them and can force state bits on through a test register. Each interrupt pin is the state bit ANDed with its mask bit.

The bus is word-indexed: the register index is the byte address shifted right by two. Index map:

| Index | Register |
|---|---|
| 0 | event state |
| 1 | event mask |
| 2 | event force |
| 3 | control |
| 4 | status |
| 5 | receive byte |
| 6 | transmit byte |
| 7 | queue control |
| 8 | queue level |

Top module: `serial_nco_port`

## Requirements
- R1: After reset, every register reads zero except status. Status reads 0x34: bit 2 is transmit-empty, bit 4 is receive-idle and bit 5 is receive-empty. All four interrupt pins are low and the serial output is high.
- R2: The serial output sends each byte as one low start bit, then eight data bits least significant bit first, then one high stop bit. Each bit lasts OVERSAMPLE × 2^20 / INC clocks, where INC is control bits 31:16.
- R3: A write to index 6 appends bits 7:0 to a 32-entry queue, and bytes leave in the order they were written. Index 8 bits 5:0 report the queue level. A write to a full queue is dropped. Status bit 0 (full) is 1 exactly when the level is 32.
- R4: While control bit 0 (transmit enable) is 0, nothing is sent and the queue level does not drop.
- R5: Writing 1 to queue-control bit 1 sets the level to zero at once. This bit always reads back as 0.
- R6: Event bit 0 (transmit watermark) is set when a write leaves the level at or above queue-control bits 13:8. It is cleared when a dequeue leaves the level below that threshold, and also when the queue drains.
- R7: When the last queued byte has finished its stop bit, event bit 2 (transmit empty) is set. Status bit 2 is 1 whenever the queue is empty and no frame is in flight.
- R8: A write to index 0 clears each event bit written as 1 and leaves the others unchanged. A write to index 2 sets each event bit written as 1. Index 2 reads as zero.
- R9: Each interrupt pin is high exactly when its event bit and its mask bit (index 1, same bit position) are both 1.
- R10: While control bit 1 (receive enable) is 1, a received frame loads its byte into index 5 and clears status bits 4 and 5. A read of index 5 returns the byte and sets both bits again.
- R11: While receive enable is 0, incoming frames are ignored. Status, events and the held byte stay unchanged.
- R12: A frame that completes while status bit 5 is 0 (byte still unread) sets event bit 3 (overflow) and is discarded. The held byte keeps its old value.
- R13: A received byte sets event bit 1 (receive watermark) only when queue-control bits 4:2 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| bus_addr_i | input | ADDR_W | Byte address; bits ADDR_W-1:2 select the register |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe; read side effects happen at the clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address, combinational |
| tx_o | output | 1 | Serial output, idles high |
| rx_i | input | 1 | Serial input, asynchronous |
| irq_tx_wm_o | output | 1 | Transmit watermark interrupt |
| irq_rx_wm_o | output | 1 | Receive watermark interrupt |
| irq_tx_empty_o | output | 1 | Transmit empty interrupt |
| irq_rx_ovf_o | output | 1 | Receive overflow interrupt |

## Verification
A wrong queue pointer or level shows up in two places. The level register reads the wrong value in the cycle after the write. The serial line, checked frame by frame against a queue of expected bytes, carries a missing, repeated or reordered byte about one frame time later. A drifting accumulator or bit counter stretches or shifts bit periods, so a mid-bit sample lands on the wrong data bit within a single frame. Errors in the receive holding logic show at the next status or event read: a byte that is lost, taken while disabled, or overwritten on overflow leaves the wrong value in the receive register or the wrong bits in status and events.

// File: rtl/snp_pkg.sv
package snp_pkg;
    // register indices (byte address >> 2)
    localparam logic [3:0] REG_ISTATE  = 4'd0;
    localparam logic [3:0] REG_IMASK   = 4'd1;
    localparam logic [3:0] REG_IFORCE  = 4'd2;
    localparam logic [3:0] REG_CTRL    = 4'd3;
    localparam logic [3:0] REG_STATUS  = 4'd4;
    localparam logic [3:0] REG_RXBYTE  = 4'd5;
    localparam logic [3:0] REG_TXBYTE  = 4'd6;
    localparam logic [3:0] REG_QCTRL   = 4'd7;
    localparam logic [3:0] REG_QLEVEL  = 4'd8;

    // event bit positions
    localparam int EV_TXWM  = 0;
    localparam int EV_RXWM  = 1;
    localparam int EV_TXMT  = 2;
    localparam int EV_RXOVF = 3;
    localparam int NUM_EV   = 4;

    localparam int INC_W     = 16;
    localparam int PHASE_W   = 20;
    localparam int CHAR_W    = 8;
    localparam int TXRST_BIT = 1;
    localparam int RXTH_W    = 3;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/snp_baud_nco.sv
module snp_baud_nco #(
    parameter int INC_W   = 16,
    parameter int PHASE_W = 20
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [INC_W-1:0] inc_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic               tick;
    } nco_t;

    nco_t nco_d, nco_q;
    logic [PHASE_W:0] sum;

    always_comb begin
        sum        = {1'b0, nco_q.phase} + (PHASE_W+1)'(inc_i);
        nco_d.phase = sum[PHASE_W-1:0];
        nco_d.tick  = sum[PHASE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) nco_q <= '0;
        else         nco_q <= nco_d;
    end

    assign tick_o = nco_q.tick;
endmodule

// File: rtl/snp_tx_fifo.sv
module snp_tx_fifo #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic [LVL_W-1:0]  level_o
);
    localparam logic [LVL_W-1:0] FULL_L = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [LVL_W-1:0] level;
    } fifo_t;

    fifo_t f_d, f_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    always_comb begin
        f_d     = f_q;
        push_ok = push_i && (f_q.level != FULL_L);
        pop_ok  = pop_i && (f_q.level != '0);
        if (clear_i) begin
            f_d = '0;
        end else begin
            if (push_ok) f_d.wptr = (f_q.wptr == LAST_P) ? '0 : f_q.wptr + 1'b1;
            if (pop_ok)  f_d.rptr = (f_q.rptr == LAST_P) ? '0 : f_q.rptr + 1'b1;
            f_d.level = f_q.level + LVL_W'(push_ok) - LVL_W'(pop_ok);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) f_q <= '0;
        else         f_q <= f_d;
    end

    always_ff @(posedge clk_i) begin
        if (push_ok && !clear_i) mem_q[f_q.wptr] <= data_i;
    end

    assign head_o  = mem_q[f_q.rptr];
    assign level_o = f_q.level;

    AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        f_q.level <= FULL_L); // R3
    AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !pop_i && !clear_i && f_q.level == FULL_L) |=> (f_q.level == FULL_L)); // R3
endmodule

// File: rtl/snp_tx_shift.sv
module snp_tx_shift #(
    parameter int OSR    = 16,
    parameter int DATA_W = 8,
    localparam int FRAME = DATA_W + 2,
    localparam int OS_W  = $clog2(OSR),
    localparam int BIT_W = $clog2(FRAME + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              tx_o,
    output logic              busy_o,
    output logic              done_o
);
    typedef struct packed {
        logic [FRAME-1:0] frame;
        logic [BIT_W-1:0] bits;
        logic [OS_W-1:0]  os;
        logic             busy;
        logic             done;
    } tx_t;

    tx_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (load_i) begin
                s_d.frame = {1'b1, data_i, 1'b0};
                s_d.bits  = BIT_W'(FRAME);
                s_d.os    = '0;
                s_d.busy  = 1'b1;
            end
        end else if (tick_i) begin
            if (s_q.os == OS_W'(OSR - 1)) begin
                s_d.os    = '0;
                s_d.frame = {1'b1, s_q.frame[FRAME-1:1]};
                s_d.bits  = s_q.bits - 1'b1;
                if (s_q.bits == BIT_W'(1)) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end
            end else begin
                s_d.os = s_q.os + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{frame: '1, bits: '0, os: '0, busy: 1'b0, done: 1'b0};
        else         s_q <= s_d;
    end

    assign tx_o   = s_q.busy ? s_q.frame[0] : 1'b1;
    assign busy_o = s_q.busy;
    assign done_o = s_q.done;

    AST_DONE_AFTER_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.done |-> $past(s_q.busy)); // R7
    AST_STOP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.busy && s_q.bits == BIT_W'(1)) |-> tx_o); // R2
endmodule

// File: rtl/snp_rx_sample.sv
module snp_rx_sample
    import snp_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8,
    localparam int OS_W  = $clog2(OSR),
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              en_i,
    input  logic              rx_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic [1:0]        sync;
        rx_state_e         st;
        logic [OS_W-1:0]   os;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              valid;
    } rx_t;

    rx_t r_d, r_q;
    logic line;

    assign line = r_q.sync[1];

    always_comb begin
        r_d       = r_q;
        r_d.sync  = {r_q.sync[0], rx_i};
        r_d.valid = 1'b0;
        unique case (r_q.st)
            RX_IDLE: begin
                if (en_i && !line) begin
                    r_d.st = RX_START;
                    r_d.os = '0;
                end
            end
            RX_START: if (tick_i) begin
                if (r_q.os == OS_W'(OSR/2 - 1)) begin
                    r_d.os  = '0;
                    r_d.idx = '0;
                    r_d.st  = line ? RX_IDLE : RX_DATA;
                end else begin
                    r_d.os = r_q.os + 1'b1;
                end
            end
            RX_DATA: if (tick_i) begin
                if (r_q.os == OS_W'(OSR - 1)) begin
                    r_d.os = '0;
                    r_d.sh = {line, r_q.sh[DATA_W-1:1]};
                    if (r_q.idx == IDX_W'(DATA_W - 1)) r_d.st = RX_STOP;
                    else                               r_d.idx = r_q.idx + 1'b1;
                end else begin
                    r_d.os = r_q.os + 1'b1;
                end
            end
            RX_STOP: if (tick_i) begin
                if (r_q.os == OS_W'(OSR - 1)) begin
                    r_d.st    = RX_IDLE;
                    r_d.valid = line && en_i;
                end else begin
                    r_d.os = r_q.os + 1'b1;
                end
            end
            default: r_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{sync: 2'b11, st: RX_IDLE, os: '0, idx: '0, sh: '0, valid: 1'b0};
        else         r_q <= r_d;
    end

    assign valid_o = r_q.valid;
    assign data_o  = r_q.sh;

    AST_VALID_FROM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.valid |-> ($past(r_q.st) == RX_STOP && $past(en_i))); // R11
endmodule

// File: rtl/serial_nco_port.sv
module serial_nco_port
    import snp_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DEPTH      = 32,
    parameter int OVERSAMPLE = 16,
    localparam int LVL_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic              bus_re_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              tx_o,
    input  logic              rx_i,
    output logic              irq_tx_wm_o,
    output logic              irq_rx_wm_o,
    output logic              irq_tx_empty_o,
    output logic              irq_rx_ovf_o
);
    localparam logic [LVL_W-1:0] FULL_L = LVL_W'(DEPTH);

    typedef struct packed {
        logic [NUM_EV-1:0] ev;
        logic [NUM_EV-1:0] mask;
        logic [INC_W-1:0]  inc;
        logic              tx_en;
        logic              rx_en;
        logic [RXTH_W-1:0] rx_th;
        logic [LVL_W-1:0]  tx_th;
        logic [CHAR_W-1:0] rbyte;
        logic              rx_empty;
        logic              rx_idle;
    } csr_t;

    csr_t c_d, c_q;

    logic [3:0]        idx;
    logic              tick, fifo_push, fifo_pop, fifo_clear, push_ok;
    logic [CHAR_W-1:0] fifo_head, rx_byte;
    logic [LVL_W-1:0]  level, lvl_after;
    logic              sh_busy, sh_done, rx_valid, rd_take, rx_free;
    logic [NUM_EV-1:0] hw_set, hw_clr;
    logic              tx_empty_st;
    logic              unused_bits;

    assign idx         = 4'(bus_addr_i[ADDR_W-1:2]);
    assign unused_bits = ^{bus_addr_i[1:0], bus_wdata_i[15:14]};

    snp_baud_nco #(.INC_W(INC_W), .PHASE_W(PHASE_W)) u_nco (
        .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(c_q.inc), .tick_o(tick));

    snp_tx_fifo #(.DEPTH(DEPTH), .DATA_W(CHAR_W)) u_fifo (
        .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(fifo_clear), .push_i(fifo_push),
        .data_i(bus_wdata_i[CHAR_W-1:0]), .pop_i(fifo_pop), .head_o(fifo_head),
        .level_o(level));

    snp_tx_shift #(.OSR(OVERSAMPLE), .DATA_W(CHAR_W)) u_txs (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .load_i(fifo_pop),
        .data_i(fifo_head), .tx_o(tx_o), .busy_o(sh_busy), .done_o(sh_done));

    snp_rx_sample #(.OSR(OVERSAMPLE), .DATA_W(CHAR_W)) u_rxs (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .en_i(c_q.rx_en),
        .rx_i(rx_i), .valid_o(rx_valid), .data_o(rx_byte));

    assign tx_empty_st = (level == '0) && !sh_busy;

    always_comb begin
        c_d        = c_q;
        fifo_clear = bus_we_i && (idx == REG_QCTRL) && bus_wdata_i[TXRST_BIT];
        fifo_push  = bus_we_i && (idx == REG_TXBYTE);
        fifo_pop   = c_q.tx_en && !sh_busy && (level != '0) && !fifo_clear;
        push_ok    = fifo_push && (level != FULL_L);
        lvl_after  = level + LVL_W'(push_ok) - LVL_W'(fifo_pop);
        hw_set     = '0;
        hw_clr     = '0;

        // transmit-side events
        if (push_ok && lvl_after >= c_q.tx_th) hw_set[EV_TXWM] = 1'b1;
        if (fifo_pop && lvl_after < c_q.tx_th) hw_clr[EV_TXWM] = 1'b1;
        if (sh_done && level == '0 && !push_ok) begin
            hw_set[EV_TXMT] = 1'b1;
            hw_clr[EV_TXWM] = 1'b1;
        end

        // receive holding register
        rd_take = bus_re_i && (idx == REG_RXBYTE) && c_q.rx_en;
        rx_free = c_q.rx_empty || rd_take;
        if (rd_take) begin
            c_d.rx_empty = 1'b1;
            c_d.rx_idle  = 1'b1;
        end
        if (rx_valid) begin
            if (rx_free) begin
                c_d.rbyte    = rx_byte;
                c_d.rx_empty = 1'b0;
                c_d.rx_idle  = 1'b0;
                if (c_q.rx_th == '0) hw_set[EV_RXWM] = 1'b1;
            end else begin
                hw_set[EV_RXOVF] = 1'b1;
            end
        end

        c_d.ev = c_q.ev & ~hw_clr;
        if (bus_we_i) begin
            unique case (idx)
                REG_ISTATE: c_d.ev = c_d.ev & ~bus_wdata_i[NUM_EV-1:0];
                REG_IMASK:  c_d.mask = bus_wdata_i[NUM_EV-1:0];
                REG_IFORCE: hw_set = hw_set | bus_wdata_i[NUM_EV-1:0];
                REG_CTRL: begin
                    c_d.tx_en = bus_wdata_i[0];
                    c_d.rx_en = bus_wdata_i[1];
                    c_d.inc   = bus_wdata_i[31:16];
                end
                REG_QCTRL: begin
                    c_d.rx_th = bus_wdata_i[4:2];
                    c_d.tx_th = bus_wdata_i[8 +: LVL_W];
                end
                default: ;
            endcase
        end
        c_d.ev = c_d.ev | hw_set;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '{ev: '0, mask: '0, inc: '0, tx_en: 1'b0, rx_en: 1'b0,
                              rx_th: '0, tx_th: '0, rbyte: '0, rx_empty: 1'b1,
                              rx_idle: 1'b1};
        else         c_q <= c_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (idx)
            REG_ISTATE: bus_rdata_o[NUM_EV-1:0] = c_q.ev;
            REG_IMASK:  bus_rdata_o[NUM_EV-1:0] = c_q.mask;
            REG_CTRL:   bus_rdata_o = {c_q.inc, 14'd0, c_q.rx_en, c_q.tx_en};
            REG_STATUS: bus_rdata_o[5:0] = {c_q.rx_empty, c_q.rx_idle, 1'b0,
                                            tx_empty_st, 1'b0, level == FULL_L};
            REG_RXBYTE: bus_rdata_o[CHAR_W-1:0] = c_q.rbyte;
            REG_QCTRL: begin
                bus_rdata_o[4:2]        = c_q.rx_th;
                bus_rdata_o[8 +: LVL_W] = c_q.tx_th;
            end
            REG_QLEVEL: bus_rdata_o[LVL_W-1:0] = level;
            default: ;
        endcase
    end

    assign irq_tx_wm_o    = c_q.ev[EV_TXWM]  & c_q.mask[EV_TXWM];
    assign irq_rx_wm_o    = c_q.ev[EV_RXWM]  & c_q.mask[EV_RXWM];
    assign irq_tx_empty_o = c_q.ev[EV_TXMT]  & c_q.mask[EV_TXMT];
    assign irq_rx_ovf_o   = c_q.ev[EV_RXOVF] & c_q.mask[EV_RXOVF];

    AST_TXRST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_clear |=> (level == '0)); // R5
    AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!c_q.tx_en && !fifo_clear) |=> (level >= $past(level))); // R4
    AST_OVF_KEEPS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_valid && !c_q.rx_empty && !rd_take) |=> (c_q.ev[EV_RXOVF] && $stable(c_q.rbyte))); // R12
    AST_RX_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!c_q.rx_en && !(bus_we_i && idx == REG_CTRL)) |=> $stable(c_q.rbyte)); // R11
endmodule

// File: tb/sim_serial_nco_port.sv
`timescale 1ns/1ps
module sim_serial_nco_port;
    localparam int INC   = 32'h8000;
    localparam int OSR   = 16;
    localparam int BIT   = OSR * (1 << 20) / INC;  // clocks per bit
    localparam int DEPTH = 32;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        we = 1'b0, re = 1'b0;
    logic [31:0] wdata = '0, rdata;
    logic        tx, rx = 1'b1;
    logic        i_txwm, i_rxwm, i_txmt, i_ovf;

    int n_tests = 0, n_fail = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    serial_nco_port u0 (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
        .bus_re_i(re), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tx_o(tx),
        .rx_i(rx), .irq_tx_wm_o(i_txwm), .irq_rx_wm_o(i_rxwm),
        .irq_tx_empty_o(i_txmt), .irq_rx_ovf_o(i_ovf));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [31:0] v);
        @(negedge clk);
        addr = 6'(idx << 2); wdata = v; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic rd(int idx, output logic [31:0] v);
        @(negedge clk);
        addr = 6'(idx << 2); re = 1'b1;
        #1 v = rdata;
        @(posedge clk); #1;
        re = 1'b0;
    endtask

    task automatic tx_enqueue(logic [7:0] b);
        exp_q.push_back(b);
        wr(6, {24'd0, b});
    endtask

    task automatic rx_send(logic [7:0] b);
        @(negedge clk);
        rx = 1'b0; repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i]; repeat (BIT) @(negedge clk);
        end
        rx = 1'b1; repeat (BIT) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    // monitor: decode frames on tx and compare against the expected queue
    initial begin
        logic [7:0] got;
        logic       sb, pb;
        forever begin
            @(negedge tx);
            repeat (BIT/2) @(negedge clk);
            sb = tx;
            for (int i = 0; i < 8; i++) begin
                repeat (BIT) @(negedge clk);
                got[i] = tx;
            end
            repeat (BIT) @(negedge clk);
            pb = tx;
            chk("R2 start bit low", {31'd0, sb}, 32'd0);
            chk("R2 stop bit high", {31'd0, pb}, 32'd1);
            if (exp_q.size() == 0) chk("R3 unexpected frame", {24'd0, got}, 32'hFFFF_FFFF);
            else chk("R2/R3 frame byte", {24'd0, got}, {24'd0, exp_q.pop_front()});
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(4, v); chk("R1 status", v, 32'h34);
        rd(0, v); chk("R1 events", v, 0);
        rd(8, v); chk("R1 level", v, 0);
        chk("R1 pins", {27'd0, tx, i_txwm, i_rxwm, i_txmt, i_ovf}, 32'h10);

        // R8 force / clear
        wr(2, 32'hA);
        rd(0, v); chk("R8 force sets", v, 32'hA);
        rd(2, v); chk("R8 force reads zero", v, 0);
        wr(0, 32'h2);
        rd(0, v); chk("R8 W1C", v, 32'h8);
        // R9 masking
        wr(1, 32'h8);
        chk("R9 ovf pin on", {28'd0, i_txwm, i_rxwm, i_txmt, i_ovf}, 32'h1);
        wr(1, 32'h7);
        chk("R9 ovf pin masked", {28'd0, i_txwm, i_rxwm, i_txmt, i_ovf}, 32'h0);
        wr(0, 32'hF); wr(1, 0);

        // R4 hold while disabled, R3 level
        wr(3, INC << 16);
        wr(6, 32'h11); wr(6, 32'h22); wr(6, 32'h33);
        rd(8, v); chk("R3 level three", v, 3);
        rd(4, v); chk("R7 txempty clear", v & 32'h4, 0);
        repeat (2000) @(negedge clk);
        chk("R4 line idle", {31'd0, tx}, 1);
        rd(8, v); chk("R4 level kept", v, 3);
        // R5 reset of queue
        wr(7, 32'h2);
        rd(8, v); chk("R5 level zero", v, 0);
        rd(7, v); chk("R5 reads zero", v & 32'h2, 0);
        // R3 full and drop
        for (int i = 0; i < DEPTH + 1; i++) wr(6, i);
        rd(8, v); chk("R3 level full", v, DEPTH);
        rd(4, v); chk("R3 full flag", v & 32'h1, 1);
        wr(7, 32'h2);

        // R6 watermark with threshold 2
        wr(7, 32'h200);
        wr(0, 32'hF);
        tx_enqueue(8'hA5);
        rd(0, v); chk("R6 below threshold", v & 1, 0);
        tx_enqueue(8'h3C);
        rd(0, v); chk("R6 at threshold", v & 1, 1);
        tx_enqueue(8'h80);
        wr(3, (INC << 16) | 1);
        repeat (6000) @(negedge clk);
        rd(8, v); chk("R3 level after pops", v, 1);
        rd(0, v); chk("R6 cleared below", v & 1, 0);
        repeat (2 * 10 * BIT) @(negedge clk);
        chk("R2 all frames seen", exp_q.size(), 0);
        rd(0, v); chk("R7 empty event", v & 32'h4, 32'h4);
        rd(4, v); chk("R7 empty status", v & 32'h4, 32'h4);
        wr(1, 32'h4);
        chk("R9 empty pin", {31'd0, i_txmt}, 1);
        wr(1, 0); wr(0, 32'hF);

        // R10 / R13 receive
        wr(7, 32'h0);
        wr(3, (INC << 16) | 2);
        rx_send(8'h96);
        rd(4, v); chk("R10 rx flags cleared", v & 32'h30, 0);
        rd(0, v); chk("R13 rx watermark", v & 32'h2, 32'h2);
        rd(5, v); chk("R10 byte", v, 32'h96);
        rd(4, v); chk("R10 rx flags set", v & 32'h30, 32'h30);
        // R13 negative
        wr(7, 32'hC); wr(0, 32'hF);
        rx_send(8'h5A);
        rd(0, v); chk("R13 no watermark", v & 32'h2, 0);
        // R12 overflow
        rx_send(8'hC3);
        rd(0, v); chk("R12 overflow event", v & 32'h8, 32'h8);
        rd(5, v); chk("R12 byte kept", v, 32'h5A);
        // R11 ignored while disabled
        wr(0, 32'hF);
        wr(3, INC << 16);
        rx_send(8'h11);
        rd(4, v); chk("R11 status unchanged", v & 32'h30, 32'h30);
        rd(0, v); chk("R11 no events", v, 0);
        rd(5, v); chk("R11 byte unchanged", v, 32'h5A);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule